// File: doc/BRIEF.md
# Synchronizable Dual Ramp Generator

This block produces two sawtooth counters that define the switching periods of two pulse-width channels. The first ramp free-runs with its own programmed period but restarts whenever a rising edge arrives on an external sync input, provided its sync select bit is set. The second ramp either runs on its own period or is chained to the first, so that it takes the first ramp's period and restarts each time the first ramp returns to zero.

Each ramp restarts at a programmable phase offset: an 8-bit phase value selects a fraction phase/256 of the period, and the ramp restarts at floor(phase * period / 256) instead of zero. Programming the second ramp with phase 256*k/n interleaves it behind the first one. The external sync input is asynchronous; it passes through a two-flop synchronizer and an edge detector. A supervision timer reports whether external sync is currently present. When pulses stop, the first ramp keeps counting on its own period with no jump in value.

Top module: `dual_ramp_gen`

## Requirements
- R1: While `rst` is high at a rising clock edge, both ramps, both start strobes and `sync_present` are 0 after that edge.
- R2: A ramp that is not being restarted counts up by one per clock and goes from period-1 to 0. A period value of 0 or 1 is treated as 2. A ramp never shows a value at or above the effective period it was last computed with.
- R3: `start0` (`start1`) is high exactly in the cycles in which `ramp0` (`ramp1`) has just taken the value 0, whether by wrapping or by a restart whose start value is 0.
- R4: With `sync_sel0` = 1, suppose `ext_sync` is sampled high at rising edge k after being sampled low at edge k-1. At edge k+2, `ramp0` is loaded with floor(`phase0` * P0 / 256), where P0 is the effective `period0`. This restart takes priority over a wrap that falls at the same edge.
- R5: With `sync_sel0` = 0, `ext_sync` has no effect on `ramp0`, which counts as in R2.
- R6: With `sync_sel1` = 1, `ramp1` uses the effective `period0`. At every edge where `ramp0` takes the value 0, `ramp1` is loaded with floor(`phase1` * P0 / 256).
- R7: With `sync_sel1` = 0, `ramp1` counts on the effective `period1` alone, and `phase1`, `ramp0` and `ext_sync` have no effect on it.
- R8: `sync_present` is set at the same edge as the restart in R4, whatever the value of `sync_sel0`. Let L = P0 + floor(P0/2). If no further sync edge follows, `sync_present` is cleared at the (L+1)-th rising edge after the one that set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_sync | input | 1 | Asynchronous external sync; rising edges restart ramp0 |
| sync_sel0 | input | 1 | 1: ramp0 accepts external sync |
| sync_sel1 | input | 1 | 1: ramp1 is chained to ramp0; 0: ramp1 runs on its own period |
| period0 | input | RAMP_W | Period of ramp0 in clocks |
| period1 | input | RAMP_W | Own period of ramp1 in clocks |
| phase0 | input | PHASE_W | Restart offset of ramp0 in 1/256 of a period |
| phase1 | input | PHASE_W | Restart offset of ramp1 in 1/256 of a period |
| ramp0 | output | RAMP_W | Ramp 0 value |
| ramp1 | output | RAMP_W | Ramp 1 value |
| start0 | output | 1 | Ramp 0 period-start strobe |
| start1 | output | 1 | Ramp 1 period-start strobe |
| sync_present | output | 1 | External sync edges are arriving |

## Verification
An external sync restart and a natural wrap of ramp0 can land on the same clock edge, and only one of them can set the next value. The bench provokes this directly. It sets period0 to 50 and phase0 to 64, so the restart value is 12. It then sends sync pulses every 38 clocks, which is exactly the distance from a restart at 12 to the next wrap. Under this stimulus every sync edge coincides with a wrap. The bench judges the priority by requiring that ramp0 returns to 12 each time and that start0 never fires in that window. A per-cycle reference model built from the requirements also meets such collisions across random periods, phases and pulse spacings.

// File: rtl/ramp_pkg.sv
package ramp_pkg;

    // where a ramp takes its period and restart events from
    typedef enum logic {
        SRC_OWN = 1'b0,
        SRC_REF = 1'b1
    } sync_src_e;

    // periods below two clocks are raised to two
    function automatic longint unsigned eff_period(longint unsigned p);
        return (p < 64'd2) ? 64'd2 : p;
    endfunction

    // restart value: phase fraction of a period, rounded down
    function automatic longint unsigned phase_start(longint unsigned ph,
                                                    longint unsigned per,
                                                    int              ph_w);
        return (ph * per) >> ph_w;
    endfunction

endpackage

// File: rtl/rg_sync_edge.sv
module rg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizer flops plus one for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q <= '0;
        end else begin
            sh_q <= {sh_q[STAGES-1:0], async_in};
        end
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/rg_sync_watch.sv
module rg_sync_watch #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rise,
    input  logic [W-1:0] period,
    output logic         present
);
    localparam int GW = W + 1;

    logic [GW-1:0] gap_q;
    logic [GW-1:0] limit;
    logic          present_q;

    // one and a half periods without an edge means sync is gone
    assign limit = {1'b0, period} + {2'b00, period[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q     <= '0;
            present_q <= 1'b0;
        end else if (rise) begin
            gap_q     <= '0;
            present_q <= 1'b1;
        end else if (gap_q >= limit) begin
            present_q <= 1'b0;
        end else begin
            gap_q <= gap_q + GW'(1);
        end
    end

    assign present = present_q;
endmodule

// File: rtl/rg_ramp_core.sv
module rg_ramp_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] period,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] ramp,
    output logic         start,
    output logic         zero_next
);
    logic [W-1:0] cnt_q, cnt_d;
    logic         start_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q >= period - W'(1)) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + W'(1);
        end
    end

    assign zero_next = (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            start_q <= zero_next;
        end
    end

    assign ramp  = cnt_q;
    assign start = start_q;
endmodule

// File: rtl/dual_ramp_gen.sv
module dual_ramp_gen
    import ramp_pkg::*;
#(
    parameter int RAMP_W      = 16,
    parameter int PHASE_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ext_sync,
    input  logic               sync_sel0,
    input  logic               sync_sel1,
    input  logic [RAMP_W-1:0]  period0,
    input  logic [RAMP_W-1:0]  period1,
    input  logic [PHASE_W-1:0] phase0,
    input  logic [PHASE_W-1:0] phase1,
    output logic [RAMP_W-1:0]  ramp0,
    output logic [RAMP_W-1:0]  ramp1,
    output logic               start0,
    output logic               start1,
    output logic               sync_present
);
    localparam int NCH = 2;

    logic              ext_rise;
    logic [RAMP_W-1:0] eff0, eff1;
    sync_src_e         src1;

    logic [RAMP_W-1:0] per_eff  [NCH];
    logic [RAMP_W-1:0] start_val[NCH];
    logic [RAMP_W-1:0] ramp_q   [NCH];
    logic              load     [NCH];
    logic              strobe   [NCH];
    logic              zero_nxt [NCH];
    logic              unused_zero;

    rg_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .async_in (ext_sync),
        .rise     (ext_rise)
    );

    assign eff0 = RAMP_W'(eff_period(64'(period0)));
    assign eff1 = RAMP_W'(eff_period(64'(period1)));
    assign src1 = sync_sel1 ? SRC_REF : SRC_OWN;

    rg_sync_watch #(.W(RAMP_W)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .rise    (ext_rise),
        .period  (eff0),
        .present (sync_present)
    );

    always_comb begin
        per_eff[0]   = eff0;
        per_eff[1]   = (src1 == SRC_REF) ? eff0 : eff1;
        start_val[0] = RAMP_W'(phase_start(64'(phase0), 64'(eff0), PHASE_W));
        start_val[1] = RAMP_W'(phase_start(64'(phase1), 64'(eff0), PHASE_W));
        load[0]      = sync_sel0 & ext_rise;
        load[1]      = (src1 == SRC_REF) & zero_nxt[0];
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ramp
        rg_ramp_core #(.W(RAMP_W)) u_core (
            .clk       (clk),
            .rst       (rst),
            .period    (per_eff[ch]),
            .load      (load[ch]),
            .load_val  (start_val[ch]),
            .ramp      (ramp_q[ch]),
            .start     (strobe[ch]),
            .zero_next (zero_nxt[ch])
        );
    end

    assign unused_zero = zero_nxt[1];

    assign ramp0  = ramp_q[0];
    assign ramp1  = ramp_q[1];
    assign start0 = strobe[0];
    assign start1 = strobe[1];
endmodule

// File: rtl/dual_ramp_chk.sv
module dual_ramp_chk
    import ramp_pkg::*;
#(
    parameter int RAMP_W  = 16,
    parameter int PHASE_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               ext_sync,
    input logic               sync_sel0,
    input logic               sync_sel1,
    input logic [RAMP_W-1:0]  period0,
    input logic [RAMP_W-1:0]  period1,
    input logic [PHASE_W-1:0] phase1,
    input logic [RAMP_W-1:0]  ramp0,
    input logic [RAMP_W-1:0]  ramp1,
    input logic               start0,
    input logic               sync_present
);
    logic              armed_q;
    logic [RAMP_W-1:0] eff0_c, eff1_c, lock_sv;

    always_ff @(posedge clk) armed_q <= !rst;

    assign eff0_c  = RAMP_W'(eff_period(64'(period0)));
    assign eff1_c  = sync_sel1 ? eff0_c : RAMP_W'(eff_period(64'(period1)));
    assign lock_sv = RAMP_W'(phase_start(64'(phase1), 64'(eff0_c), PHASE_W));

    // R2
    ramp0_range_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $stable(period0) |-> ramp0 < eff0_c);

    // R2
    ramp1_range_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && $stable(period0) && $stable(period1) && $stable(sync_sel1)
        |-> ramp1 < eff1_c);

    // R5
    ramp0_count_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && !$past(sync_sel0)
        |-> ramp0 == (($past(ramp0) >= $past(eff0_c) - RAMP_W'(1))
                      ? '0 : $past(ramp0) + RAMP_W'(1)));

    // R6
    ramp1_lock_chk: assert property (@(posedge clk) disable iff (rst)
        armed_q && start0 && $past(sync_sel1) |-> ramp1 == $past(lock_sv));

    // R8
    present_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sync_present) |-> $past(ext_sync, 3));
endmodule

bind dual_ramp_gen dual_ramp_chk #(.RAMP_W(RAMP_W), .PHASE_W(PHASE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .ext_sync     (ext_sync),
    .sync_sel0    (sync_sel0),
    .sync_sel1    (sync_sel1),
    .period0      (period0),
    .period1      (period1),
    .phase1       (phase1),
    .ramp0        (ramp0),
    .ramp1        (ramp1),
    .start0       (start0),
    .sync_present (sync_present)
);

// File: tb/test_dual_ramp_gen.sv
`timescale 1ns/1ps
module test_dual_ramp_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ext_sync = 1'b0;
    logic         sync_sel0 = 1'b1;
    logic         sync_sel1 = 1'b1;
    logic [W-1:0] period0 = 16'd100;
    logic [W-1:0] period1 = 16'd100;
    logic [7:0]   phase0 = 8'd0;
    logic [7:0]   phase1 = 8'd0;
    logic [W-1:0] ramp0, ramp1;
    logic         start0, start1, sync_present;

    int    n_chk = 0;
    int    n_fail = 0;
    int    st0_seen = 0;
    string tag0 = "R2";
    string tag1 = "R6";

    // reference model state
    bit ms1, ms2, ms3, mst0, mst1, mpres;
    int mr0, mr1, mgap;

    always #2.5 clk = ~clk;

    dual_ramp_gen i_dual_ramp_gen (
        .clk(clk), .rst(rst), .ext_sync(ext_sync),
        .sync_sel0(sync_sel0), .sync_sel1(sync_sel1),
        .period0(period0), .period1(period1),
        .phase0(phase0), .phase1(phase1),
        .ramp0(ramp0), .ramp1(ramp1),
        .start0(start0), .start1(start1),
        .sync_present(sync_present)
    );

    function automatic int eff_p(int p);
        return (p < 2) ? 2 : p;
    endfunction

    function automatic int start_of(int ph, int p);
        return (ph * p) / 256;
    endfunction

    always @(posedge clk) begin : model
        int e0, e1, n0, n1, lim;
        bit edge_v;
        if (rst) begin
            ms1 = 0; ms2 = 0; ms3 = 0;
            mr0 = 0; mr1 = 0; mst0 = 0; mst1 = 0; mgap = 0; mpres = 0;
        end else begin
            e0 = eff_p(int'(period0));
            e1 = sync_sel1 ? e0 : eff_p(int'(period1));
            edge_v = ms2 && !ms3;
            if (sync_sel0 && edge_v) n0 = start_of(int'(phase0), e0);
            else if (mr0 >= e0 - 1)  n0 = 0;
            else                     n0 = mr0 + 1;
            if (sync_sel1 && n0 == 0) n1 = start_of(int'(phase1), e0);
            else if (mr1 >= e1 - 1)   n1 = 0;
            else                      n1 = mr1 + 1;
            lim = e0 + e0 / 2;
            if (edge_v) begin mgap = 0; mpres = 1; end
            else if (mgap >= lim) mpres = 0;
            else mgap = mgap + 1;
            ms3 = ms2; ms2 = ms1; ms1 = ext_sync;
            mr0 = n0; mr1 = n1;
            mst0 = (n0 == 0); mst1 = (n1 == 0);
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk(tag0, int'(ramp0), mr0, "ramp0");
        chk(tag1, int'(ramp1), mr1, "ramp1");
        chk("R3", int'(start0), int'(mst0), "start0");
        chk("R3", int'(start1), int'(mst1), "start1");
        chk("R8", int'(sync_present), int'(mpres), "sync_present");
        if (start0) st0_seen++;
    endtask

    task automatic run(int cycles, int sper, int wid);
        for (int i = 0; i < cycles; i++) begin
            tick();
            ext_sync = (sper > 0) && ((i % sper) < wid);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : stim
        void'($urandom(32'h5A17_C0DE));
        // R1: outputs held at zero during reset
        repeat (4) @(negedge clk);
        chk("R1", int'(ramp0), 0, "ramp0 in reset");
        chk("R1", int'(ramp1), 0, "ramp1 in reset");
        chk("R1", int'(start0) + int'(start1), 0, "strobes in reset");
        chk("R1", int'(sync_present), 0, "sync_present in reset");
        rst = 1'b0;

        // R2/R6: free-running ramp0, ramp1 chained with quarter offset
        phase1 = 8'd64; tag0 = "R2"; tag1 = "R6";
        run(450, 0, 1);

        // R7: ramp1 on its own period, phase1 changes must not matter
        sync_sel1 = 1'b0; period1 = 16'd77; phase1 = 8'd200; tag1 = "R7";
        run(400, 0, 1);
        phase1 = 8'd13;
        run(200, 0, 1);

        // R2: degenerate periods treated as two
        period0 = 16'd1; period1 = 16'd0;
        run(50, 0, 1);

        // R4: external sync with half-period offset, then fallback (R8)
        period0 = 16'd100; period1 = 16'd77; phase0 = 8'd128; tag0 = "R4";
        run(601, 120, 1);
        run(130, 0, 1);
        chk("R8", int'(sync_present), 1, "present before timeout");
        run(40, 0, 1);
        chk("R8", int'(sync_present), 0, "present after timeout");
        tag0 = "R2";
        run(300, 0, 1);

        // R5: sync ignored by ramp0 when not selected
        sync_sel0 = 1'b0; tag0 = "R5";
        run(500, 60, 2);

        // R4: every sync edge collides with a wrap; restart must win
        sync_sel0 = 1'b1; sync_sel1 = 1'b1; period0 = 16'd50; phase0 = 8'd64;
        tag0 = "R4"; tag1 = "R6";
        run(114, 38, 1);
        st0_seen = 0;
        run(380, 38, 1);
        chk("R4", st0_seen, 0, "start0 pulses while restart beats wrap");
        chk("R4", int'(ramp0) >= 12 ? 1 : 0, 1, "ramp0 stays at or above restart value");

        // random mix of all modes
        for (int r = 0; r < 10; r++) begin
            int sper, wid;
            sync_sel0 = 1'($urandom_range(1, 0));
            sync_sel1 = 1'($urandom_range(1, 0));
            period0 = W'($urandom_range(300, 0));
            period1 = W'($urandom_range(300, 0));
            phase0 = 8'($urandom_range(255, 0));
            phase1 = 8'($urandom_range(255, 0));
            sper = ($urandom_range(3, 0) == 0) ? 0 : int'($urandom_range(400, 4));
            wid = int'($urandom_range(3, 1));
            if (sper == 0) tag0 = "R2";
            else if (sync_sel0) tag0 = "R4";
            else tag0 = "R5";
            tag1 = sync_sel1 ? "R6" : "R7";
            run(2500, sper, wid);
        end

        summary();
        $finish;
    end
endmodule